// File: doc/BRIEF.md
# Interleaved Video Scanout Engine

This block drives a raster display from a frame buffer held in memory that it shares with a processor. Each memory cycle spans two pixel clocks. The first clock is the video half, in which the engine presents its display address and captures the returned byte. The second clock is left to the processor. Because video reads sit in their own half of every memory cycle, the processor spends no time on video output.

Horizontal and vertical timing come from two instances of one segment state machine. Its states are `SEG_ACTIVE`, `SEG_FRONT`, `SEG_SYNC` and `SEG_BACK`. Each state lasts its parameterised length, and the transitions run ACTIVE→FRONT→SYNC→BACK→ACTIVE. The horizontal machine steps on every clock. The vertical machine steps on the last clock of each line. The byte address counter is a separate register. It moves only during visible pixels and returns to zero at the end of every frame.

There are two pixel formats, chosen by an input that is sampled once per frame. In 16-colour mode each byte holds two 4-bit pixels and the high nibble is shown first. In 256-colour mode each byte is one pixel, shown for two clocks, and every row of bytes is shown on two lines. This gives a quarter-area picture.

Top module: `vs_scanout`

## Requirements
- R1: A line lasts H_VIS+H_FP+H_SYNC+H_BP clocks. `hsync_n` is low for H_SYNC clocks, starting H_VIS+H_FP clocks after the line begins, and it is registered one clock behind the line position.
- R2: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines. `vsync_n` is low during lines V_VIS+V_FP through V_VIS+V_FP+V_SYNC-1, counting the first line of the frame as line 0.
- R3: `vid_slot` is 1 on the even clocks of each line (column 0, 2, …), which form the video half of the memory cycle. It is 0 on the odd clocks, which form the processor half.
- R4: On each even visible clock, `mem_addr` is the byte address of the current pixel pair. In 16-colour mode that address is row×(H_VIS/2)+column/2, contiguous across lines.
- R5: In 16-colour mode (`mode_256`=0), bits 7:4 of the fetched byte appear on `pixel[3:0]` for the even column and bits 3:0 for the odd column. `pixel[7:4]` is 0.
- R6: In 256-colour mode, the whole byte at (row/2)×(H_VIS/2)+column/2 appears on `pixel` for both columns of the pair.
- R7: `pixel` is 0 for every position outside the visible area.
- R8: The byte address is 0 at the first pixel of every frame.
- R9: `mode_256` is sampled only on the last clock of a frame. A change in the middle of a frame has no effect until the next frame starts.
- R10: While in reset, `hsync_n` and `vsync_n` are 1, `pixel` is 0 and `mem_addr` is 0. The first frame after reset uses 16-colour mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Asynchronous reset, active high |
| mode_256 | input | 1 | 1 selects one pixel per byte with line doubling; sampled at frame end |
| mem_rdata | input | 8 | Byte returned by memory for the current address |
| mem_addr | output | ADDR_W | Video byte address |
| vid_slot | output | 1 | 1 in the video half of the memory cycle, 0 in the processor half |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pixel | output | 8 | Pixel colour code: 4-bit in 16-colour mode, 8-bit in 256-colour mode |

## Verification
The bench builds the engine with 8-column, 6-row frames and porch and sync lengths of one or two. A frame therefore takes 140 clocks, so many complete frames in both formats fit in a short run. Over those frames the bench exercises every segment transition of both state machines, the address wrap at frame end, line doubling at odd and even rows, and mode changes made in the middle of a frame. ADDR_W keeps its 20-bit default. The bench memory decodes only the low address bits, which is enough because a small frame stays far below that range.

// File: rtl/vs_pkg.sv
`timescale 1ns/1ps
package vs_pkg;
    // Phases of one display axis, in scan order.
    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

    localparam int PIX_W  = 8;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/vs_segcount.sv
`timescale 1ns/1ps
module vs_segcount
    import vs_pkg::*;
#(
    parameter int ACT_LEN  = 640,
    parameter int FP_LEN   = 16,
    parameter int SYNC_LEN = 96,
    parameter int BP_LEN   = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic act_o,
    output logic sync_o,
    output logic odd_o,
    output logic act_last_o,
    output logic wrap_o
);
    localparam int TOTAL = ACT_LEN + FP_LEN + SYNC_LEN + BP_LEN;
    localparam int CW    = (TOTAL > 2) ? $clog2(TOTAL) : 1;
    localparam logic [CW-1:0] ACT_M1  = CW'(ACT_LEN - 1);
    localparam logic [CW-1:0] FP_M1   = CW'(FP_LEN - 1);
    localparam logic [CW-1:0] SYNC_M1 = CW'(SYNC_LEN - 1);
    localparam logic [CW-1:0] BP_M1   = CW'(BP_LEN - 1);

    seg_e           seg_q, seg_d;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  len_m1;
    logic           seg_last;

    // Next state and length of the current phase
    always_comb begin
        unique case (seg_q)
            SEG_ACTIVE: begin seg_d = SEG_FRONT;  len_m1 = ACT_M1;  end
            SEG_FRONT:  begin seg_d = SEG_SYNC;   len_m1 = FP_M1;   end
            SEG_SYNC:   begin seg_d = SEG_BACK;   len_m1 = SYNC_M1; end
            SEG_BACK:   begin seg_d = SEG_ACTIVE; len_m1 = BP_M1;   end
        endcase
    end

    assign seg_last = (cnt_q == len_m1);

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            seg_q <= SEG_ACTIVE;
            cnt_q <= '0;
        end else if (step) begin
            if (seg_last) begin
                seg_q <= seg_d;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        act_o      = (seg_q == SEG_ACTIVE);
        sync_o     = (seg_q == SEG_SYNC);
        odd_o      = cnt_q[0];
        act_last_o = (seg_q == SEG_ACTIVE) && seg_last;
        wrap_o     = (seg_q == SEG_BACK) && seg_last && step;
    end

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (seg_q == SEG_ACTIVE && cnt_q == '0)); // R1
    AST_SEG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (step && !seg_last) |=> (seg_q == $past(seg_q))); // R2
endmodule

// File: rtl/vs_fetch.sv
`timescale 1ns/1ps
module vs_fetch #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_act,
    input  logic              h_odd,
    input  logic              h_act_last,
    input  logic              v_act,
    input  logic              v_odd,
    input  logic              frame_last,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              mode_o
);
    logic [ADDR_W-1:0] addr_q, base_q;
    logic              mode_q;
    logic              pair_done;

    assign pair_done = h_act && v_act && h_odd;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q <= '0;
            base_q <= '0;
            mode_q <= 1'b0;
        end else if (frame_last) begin
            addr_q <= '0;
            base_q <= '0;
            mode_q <= mode_i;
        end else if (pair_done) begin
            if (h_act_last) begin
                if (mode_q && !v_odd) begin
                    addr_q <= base_q;            // repeat this row
                end else begin
                    addr_q <= addr_q + 1'b1;
                    base_q <= addr_q + 1'b1;
                end
            end else begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    assign addr_o = addr_q;
    assign mode_o = mode_q;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (pair_done && !h_act_last) |=> (addr_q == $past(addr_q) + 1'b1)); // R4
    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!(h_act && v_act) && !frame_last) |=> $stable(addr_q)); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(mode_q)); // R9
    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> (addr_q == '0 && base_q == '0)); // R8
endmodule

// File: rtl/vs_pixel.sv
`timescale 1ns/1ps
module vs_pixel
    import vs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vis_i,
    input  logic              odd_i,
    input  logic              wide_i,
    input  logic [BYTE_W-1:0] rdata_i,
    input  logic              hs_i,
    input  logic              vs_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              hsync_n_o,
    output logic              vsync_n_o
);
    logic [BYTE_W-1:0] byte_q;
    logic [PIX_W-1:0]  pix_d;

    always_comb begin
        if (!vis_i)
            pix_d = '0;
        else if (wide_i)
            pix_d = odd_i ? byte_q : rdata_i;
        else
            pix_d = {4'b0000, odd_i ? byte_q[3:0] : rdata_i[7:4]};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            byte_q    <= '0;
            pix_o     <= '0;
            hsync_n_o <= 1'b1;
            vsync_n_o <= 1'b1;
        end else begin
            if (vis_i && !odd_i)
                byte_q <= rdata_i;
            pix_o     <= pix_d;
            hsync_n_o <= ~hs_i;
            vsync_n_o <= ~vs_i;
        end
    end

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        !vis_i |=> (pix_o == '0)); // R7
    AST_NIBBLE_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !wide_i |=> (pix_o[7:4] == 4'b0000)); // R5
    AST_WIDE_PAIR_SAME: assert property (@(posedge clk) disable iff (rst)
        (vis_i && wide_i && odd_i) |=> (pix_o == $past(byte_q))); // R6
endmodule

// File: rtl/vs_scanout.sv
`timescale 1ns/1ps
module vs_scanout
    import vs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_256,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              vid_slot,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic [7:0]        pixel
);
    logic phase_q;
    logic h_act, h_sync, h_odd, h_act_last, h_wrap;
    logic v_act, v_sync, v_odd, v_act_last, v_wrap;
    logic mode_q;

    // Memory-cycle phase: 0 = video half, 1 = processor half
    always_ff @(posedge clk or posedge rst) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end
    assign vid_slot = ~phase_q;

    vs_segcount #(
        .ACT_LEN(H_VIS), .FP_LEN(H_FP), .SYNC_LEN(H_SYNC), .BP_LEN(H_BP)
    ) i_hseg (
        .clk(clk), .rst(rst), .step(1'b1),
        .act_o(h_act), .sync_o(h_sync), .odd_o(h_odd),
        .act_last_o(h_act_last), .wrap_o(h_wrap)
    );

    vs_segcount #(
        .ACT_LEN(V_VIS), .FP_LEN(V_FP), .SYNC_LEN(V_SYNC), .BP_LEN(V_BP)
    ) i_vseg (
        .clk(clk), .rst(rst), .step(h_wrap),
        .act_o(v_act), .sync_o(v_sync), .odd_o(v_odd),
        .act_last_o(v_act_last), .wrap_o(v_wrap)
    );

    vs_fetch #(.ADDR_W(ADDR_W)) i_fetch (
        .clk(clk), .rst(rst),
        .h_act(h_act), .h_odd(h_odd), .h_act_last(h_act_last),
        .v_act(v_act), .v_odd(v_odd), .frame_last(v_wrap),
        .mode_i(mode_256), .addr_o(mem_addr), .mode_o(mode_q)
    );

    vs_pixel i_pixel (
        .clk(clk), .rst(rst),
        .vis_i(h_act && v_act), .odd_i(h_odd), .wide_i(mode_q),
        .rdata_i(mem_rdata), .hs_i(h_sync), .vs_i(v_sync),
        .pix_o(pixel), .hsync_n_o(hsync_n), .vsync_n_o(vsync_n)
    );

    AST_SLOT_PARITY: assert property (@(posedge clk) disable iff (rst)
        h_act |-> (phase_q == h_odd)); // R3
    AST_LINE_START_VIDEO: assert property (@(posedge clk) disable iff (rst)
        h_wrap |=> vid_slot); // R3
    AST_LAST_ROW_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (v_act_last && h_wrap) |=> !v_act); // R2
endmodule

// File: tb/test_vs_scanout.sv
`timescale 1ns/1ps
module test_vs_scanout;
    localparam int HV = 8, HF = 2, HS = 2, HB = 2;
    localparam int VV = 6, VF = 1, VS = 1, VB = 2;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FR = HT * VT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_256 = 1'b0;
    logic [7:0]  mem_rdata;
    logic [19:0] mem_addr;
    logic        vid_slot, hsync_n, vsync_n;
    logic [7:0]  pixel;

    always #4 clk = ~clk;

    logic [7:0] mem [0:255];
    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    assign mem_rdata = mem[mem_addr[7:0]];

    vs_scanout #(
        .ADDR_W(20), .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
    ) i_vs_scanout (
        .clk(clk), .rst(rst), .mode_256(mode_256), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .vid_slot(vid_slot), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .pixel(pixel)
    );

    int    total = 0, bad = 0;
    bit    done = 0;
    int    k = 0;
    bit    mode_cur = 0;
    int    e_pix = 0, e_hs = 1, e_vs = 1;
    string e_tag = "R10";

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            if (bad < 30)
                $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, k, act, exp);
        end
    endtask

    // Behavioural reference, one step per clock, sampled 3 ns after the edge
    task automatic run(int n);
        for (int c = 0; c < n; c++) begin
            int h, v, row, a, b;
            bit vis;
            h   = k % HT;
            v   = (k / HT) % VT;
            vis = (h < HV) && (v < VV);
            chk(e_tag, pixel, e_pix);
            chk("R1", hsync_n, e_hs);
            chk("R2", vsync_n, e_vs);
            chk("R3", vid_slot, (h % 2 == 0) ? 1 : 0);
            row = mode_cur ? v / 2 : v;
            a   = row * (HV / 2) + h / 2;
            if (vis && h % 2 == 0)
                chk((h == 0 && v == 0) ? "R8" : "R4", int'(mem_addr), a);
            b = vis ? int'(mem[a]) : 0;
            if (!vis)          e_pix = 0;
            else if (mode_cur) e_pix = b;
            else               e_pix = (h % 2 == 0) ? (b >> 4) : (b & 15);
            if (!vis)                    e_tag = "R7";
            else if (mode_cur != mode_256) e_tag = "R9";
            else if (mode_cur)           e_tag = "R6";
            else                         e_tag = "R5";
            e_hs = (h >= HV + HF && h < HV + HF + HS) ? 0 : 1;
            e_vs = (v >= VV + VF && v < VV + VF + VS) ? 0 : 1;
            if (h == HT - 1 && v == VT - 1) mode_cur = mode_256;
            k++;
            @(posedge clk);
            #3;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk("R10", pixel, 0);
        chk("R10", hsync_n, 1);
        chk("R10", vsync_n, 1);
        chk("R10", int'(mem_addr), 0);
        rst = 1'b0;
        run(2 * FR + 50);
        mode_256 = 1'b1;          // mid-frame: waits for the frame boundary (R9)
        run(FR - 50 + 3 * FR + 70);
        mode_256 = 1'b0;
        run(2 * FR + 20);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule